// File: doc/BRIEF.md
# Bit-Serial-Stage Pipelined Ripple Adder

This block adds two unsigned words through a carry chain that is cut after every bit position, so each clock period only has to cover a single one-bit full adder. A fresh pair of operands can be presented on every clock, and once the pipeline has filled, one complete sum leaves per clock. Operand bits enter through a triangle of skew registers. Each bit therefore reaches its full adder in the same cycle as the carry rippling up from the bit below. A mirrored triangle of deskew registers on the sum bits reassembles every result into one aligned word together with its carry-out.

A valid flag travels beside the data and marks which output cycles carry a real result. Bubbles (cycles with the input flag low) may be mixed freely into the stream. The carry into the lowest bit is always zero. The data registers hold no reset value; only the valid flags are cleared by reset.

Top module: `pipe_ripple_adder`

## Requirements
- R1: When `out_valid` is high, `{out_carry, out_sum}` equals the 33-bit unsigned sum of the `in_a` and `in_b` sampled with the matching `in_valid`, with a carry into bit 0 of zero.
- R2: `out_valid` rises for a given operand pair exactly WIDTH (32) clock edges after the edge that sampled `in_valid` high, counting that edge as the first.
- R3: Operand pairs presented on consecutive cycles each produce their own correct result on consecutive output cycles, with no interference between neighbours in the pipeline.
- R4: A cycle with `in_valid` low produces a cycle with `out_valid` low exactly WIDTH edges later, and the operand values presented in that cycle have no effect on any valid result.
- R5: While `rst_n` is low at a clock edge, all in-flight valid flags are cleared. After release, `out_valid` stays low until a pair accepted after the release has travelled the full latency.
- R6: A carry that ripples through every bit position is handled: all-ones plus one gives a zero sum with carry-out 1, and all-ones plus all-ones gives 0xFFFFFFFE with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears valid flags |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is to be added |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | `out_sum`/`out_carry` hold a completed result |
| out_sum | output | 32 | Sum word, all bits aligned |
| out_carry | output | 1 | Carry out of the top bit position |

## Verification
The hardest case to reach is a carry that must walk through all thirty-two stages while different operand pairs occupy the neighbouring stages. If skew or deskew depths are off by one, bits of one pair then mix with carries of another. The stimulus places full-length ripple patterns (all-ones plus one, alternating bit patterns whose sum ripples) directly between random pairs in an unbroken stream, so each such pair has live neighbours in every stage. A reset pulse in the middle of a randomly gapped stream checks that results already in flight are discarded and that nothing valid emerges before a full latency has passed.

// File: rtl/padd_pkg.sv
// Package: shared types and the one-bit add used by every stage.
// Assumes nothing beyond 1-bit scalar inputs.
package padd_pkg;

    // Result of a single-bit full add
    typedef struct packed {
        logic carry;
        logic sum;
    } fa_out_t;

    // One-bit full add: sum and carry of three input bits
    function automatic fa_out_t full_add(input logic a, input logic b, input logic c);
        fa_out_t r;
        r.sum   = a ^ b ^ c;
        r.carry = (a & b) | (a & c) | (b & c);
        return r;
    endfunction

endpackage

// File: rtl/padd_delay.sv
// Module: padd_delay
// Fixed-depth shift line for a small data word, used for operand skew and
// sum deskew. Assumes DEPTH >= 1; data registers carry no reset value.
module padd_delay #(
    parameter int DEPTH = 1,
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [DEPTH];

    // Shift the word one register further along the line each cycle
    always_ff @(posedge clk) begin
        stage_q[0] <= din;
        for (int k = 1; k < DEPTH; k++) begin
            stage_q[k] <= stage_q[k-1];
        end
    end

    assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/padd_bit_stage.sv
// Module: padd_bit_stage
// One segment of the carry chain: a single full adder whose sum and carry-out
// are registered. Assumes its operand bits are already aligned with cin.
module padd_bit_stage
    import padd_pkg::*;
(
    input  logic clk,
    input  logic op_a,
    input  logic op_b,
    input  logic cin,
    output logic sum_q,
    output logic cout_q
);

    fa_out_t fa;

    // Combinational one-bit add
    always_comb fa = full_add(op_a, op_b, cin);

    // Register the stage result at the segment boundary
    always_ff @(posedge clk) begin
        sum_q  <= fa.sum;
        cout_q <= fa.carry;
    end

endmodule

// File: rtl/padd_valid_pipe.sv
// Module: padd_valid_pipe
// Valid flag line matching the data latency of the adder. Assumes
// DEPTH >= 2; synchronous active-low reset empties the whole line.
module padd_valid_pipe #(
    parameter int DEPTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic vout
);

    logic [DEPTH-1:0] flag_q;

    // Advance the valid flags, clearing all of them on reset
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= {flag_q[DEPTH-2:0], vin};
    end

    assign vout = flag_q[DEPTH-1];

endmodule

// File: rtl/pipe_ripple_adder.sv
// Module: pipe_ripple_adder (top)
// Unsigned adder with a register after every bit position of the ripple
// chain. Operand bit i is delayed i cycles, sum bit i is delayed WIDTH-1-i
// cycles, so results leave aligned WIDTH cycles after acceptance.
// Assumes WIDTH >= 2; carry into bit 0 is zero; no stall.
module pipe_ripple_adder #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_carry
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum_raw;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] ab_al;

        // Operand skew: bit i waits i cycles for its carry
        if (i == 0) begin : g_noskew
            assign ab_al = {in_a[i], in_b[i]};
        end else begin : g_skew
            padd_delay #(.DEPTH(i), .WIDTH(2)) u_skew (
                .clk  (clk),
                .din  ({in_a[i], in_b[i]}),
                .dout (ab_al)
            );
        end

        padd_bit_stage u_stage (
            .clk    (clk),
            .op_a   (ab_al[1]),
            .op_b   (ab_al[0]),
            .cin    (carry[i]),
            .sum_q  (sum_raw[i]),
            .cout_q (carry[i+1])
        );

        // Sum deskew: bit i waits for the slower upper bits
        if (i == TOP) begin : g_nodeskew
            assign out_sum[i] = sum_raw[i];
        end else begin : g_deskew
            padd_delay #(.DEPTH(TOP - i), .WIDTH(1)) u_deskew (
                .clk  (clk),
                .din  (sum_raw[i]),
                .dout (out_sum[i])
            );
        end
    end

    assign out_carry = carry[WIDTH];

    padd_valid_pipe #(.DEPTH(WIDTH)) u_valid (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (in_valid),
        .vout  (out_valid)
    );

endmodule

// File: rtl/padd_checker.sv
// Module: padd_checker
// Temporal properties of the pipelined adder's valid protocol, bound to the
// top module. Uses counters rather than deep $past windows.
module padd_checker #(
    parameter int W = 32
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid
);

    localparam int SW = $clog2(W + 1);
    localparam int CW = $clog2(W + 1) + 1;

    logic [SW-1:0] since_rst;
    logic [CW-1:0] inflight;

    // Cycles since reset release, saturating at W
    always_ff @(posedge clk) begin
        if (!rst_n)                     since_rst <= '0;
        else if (since_rst != SW'(W))   since_rst <= since_rst + 1'b1;
    end

    // Accepted pairs not yet delivered
    always_ff @(posedge clk) begin
        if (!rst_n)                       inflight <= '0;
        else if (in_valid && !out_valid)  inflight <= inflight + 1'b1;
        else if (!in_valid && out_valid)  inflight <= inflight - 1'b1;
    end

    // R2: no result can appear before a full latency after reset
    a_r2_fill_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < SW'(W)) |-> !out_valid);

    // R3: the pipeline never holds more than W pairs
    a_r3_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CW'(W));

    // R4: a valid output always has an accepted pair behind it
    a_r4_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != '0));

    // R5: valid flags are empty right after reset release
    a_r5_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

endmodule

bind pipe_ripple_adder padd_checker #(.W(WIDTH)) u_padd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid)
);

// File: tb/test_pipe_ripple_adder.sv
// Bench for pipe_ripple_adder: directed ripple corners plus seeded random
// stream with bubbles and a mid-stream reset.
module test_pipe_ripple_adder;

    localparam int W     = 32;
    localparam int NCYC  = 700;
    localparam int RSTAT = 400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_a = '0;
    logic [W-1:0]  in_b = '0;
    logic          out_valid;
    logic [W-1:0]  out_sum;
    logic          out_carry;

    int total = 0;
    int bad   = 0;

    logic [W:0] exp_sum [NCYC];
    logic       exp_v   [NCYC];
    int         tag     [NCYC];

    always #5 clk = ~clk;

    pipe_ripple_adder #(.WIDTH(W)) i_pipe_ripple_adder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_carry (out_carry)
    );

    // Reference 33-bit sum with zero carry-in
    function automatic logic [W:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    // Directed corner operands, index k
    function automatic logic [2*W-1:0] corner(input int k);
        case (k % 6)
            0: return {32'hFFFF_FFFF, 32'h0000_0001};
            1: return {32'hFFFF_FFFF, 32'hFFFF_FFFF};
            2: return {32'hAAAA_AAAA, 32'h5555_5556};
            3: return {32'h8000_0000, 32'h8000_0000};
            4: return {32'h0000_0000, 32'h0000_0000};
            default: return {32'h7FFF_FFFF, 32'h0000_0001};
        endcase
    endfunction

    task automatic check(input int n);
        logic ev;
        ev = (n >= W) ? exp_v[n-W] : 1'b0;
        total++;
        if (out_valid !== ev) begin
            bad++;
            $display("FAIL %s cycle %0d out_valid act=%b exp=%b",
                     (n < W || n > RSTAT) ? "R5/R2" : "R2/R4", n, out_valid, ev);
        end else if (ev) begin
            total++;
            if ({out_carry, out_sum} !== exp_sum[n-W]) begin
                bad++;
                $display("FAIL %s cycle %0d sum act=%h exp=%h",
                         (tag[n-W] == 6) ? "R6" : "R1/R3", n,
                         {out_carry, out_sum}, exp_sum[n-W]);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int n = 0; n < NCYC; n++) begin
            @(negedge clk);
            check(n);
            // reset: first 4 cycles, and 2 cycles at RSTAT (R5)
            rst_n = !((n < 4) || (n == RSTAT) || (n == RSTAT + 1));
            if (!rst_n) begin
                for (int m = 0; m < n; m++) exp_v[m] = 1'b0;
                in_valid = $urandom_range(0, 1);
                in_a = $urandom();
                in_b = $urandom();
            end else if (n < 40) begin
                // R6/R3: ripple corners between random neighbours, no bubbles
                in_valid = 1'b1;
                if (n % 2 == 0) {in_a, in_b} = corner(n / 2);
                else begin in_a = $urandom(); in_b = $urandom(); end
            end else if (n < 550) begin
                // R4: random bubbles with junk operands
                in_valid = ($urandom_range(0, 3) != 0);
                in_a = $urandom();
                in_b = $urandom();
            end else begin
                // R3: dense random stream
                in_valid = 1'b1;
                in_a = $urandom();
                in_b = $urandom();
            end
            exp_v[n]   = in_valid && rst_n;
            exp_sum[n] = ref_sum(in_a, in_b);
            tag[n]     = (n >= 4 && n < 40 && n % 2 == 0) ? 6 : 1;
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule